// File: doc/BRIEF.md
# SPI Baud Clock Generator

This block turns a fast peripheral clock into the serial clock of an SPI controller. A programmable rate value sets the divisor. Values from 0 to 3 give a divisor of 4. Any larger value `v` gives a divisor of `v + 1`. While the block is disabled, the serial clock rests at an idle level chosen by a polarity input.

Each period starts by leaving the idle level. This is the leading edge. The clock returns to the idle level partway through the period, which is the trailing edge. When the divisor is odd, the two phases cannot be equal, and the idle-level phase gets the extra cycle. With polarity 0 the low phase is longer; with polarity 1 the high phase is longer. A neighbouring shift register does not have to find the edges itself. It gets a one-cycle strobe for every leading edge and another for every trailing edge. Each strobe is high in the first cycle that the serial clock shows its new level.

The rate value and the polarity are captured only at a leading edge. A change made during a period therefore never shortens or stretches the phase in progress.

Top module: `spi_baud_clkgen`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `sclk` is 0 and both strobes are 0.
- R2: If `en` is low at a clock edge, then after that edge `sclk` equals `cpol` as sampled at that edge, and neither strobe is asserted.
- R3: For a rate value greater than 3, one serial clock period lasts exactly rate + 1 peripheral clock cycles.
- R4: When the divisor is even, the high phase and the low phase each last half the divisor.
- R5: With `cpol` = 0 and an odd divisor, the low phase is one cycle longer than the high phase (rate 4 gives 2 high, 3 low).
- R6: With `cpol` = 1 and an odd divisor, the high phase is one cycle longer than the low phase (rate 4 gives 3 high, 2 low).
- R7: Rate values 0, 1, 2 and 3 all give a 4-cycle period: 2 cycles high and 2 cycles low.
- R8: A rate value change takes effect only at the next leading edge; the period already in progress keeps its old length.
- R9: Every period has exactly one `lead_stb` cycle and one `trail_stb` cycle, and the two strobes are never high together.
- R10: At the first clock edge that finds `en` high while the block is stopped, `sclk` changes to the inverse of `cpol` and `lead_stb` goes high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Runs the generator when high; forces the idle level when low |
| brr | input | BRR_W | Rate value; divisor is 4 for values 0..3, otherwise value + 1 |
| cpol | input | 1 | Idle level of the serial clock (0 low, 1 high) |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse in the first cycle after the clock leaves the idle level |
| trail_stb | output | 1 | One-cycle pulse in the first cycle after the clock returns to the idle level |

## Verification
The division is tried with the clamped rate values 0 and 3, with small even and odd divisors under both polarities, and with the largest even and odd divisors. Together these patterns separate the clamp from plain value + 1 division. They also show whether the extra cycle of an odd divisor goes to the correct phase for each polarity, and whether the counter fails at full width. Directed runs change the rate value during an active phase to confirm it is captured only at a leading edge. Further runs disable the block during a period, and change the polarity while the block is stopped.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

    // Rate values up to this one are clamped to the minimum divisor.
    localparam int unsigned SMALL_RATE_MAX = 3;
    localparam int unsigned MIN_DIVISOR    = 4;

    // Where the generator is inside a serial clock period.
    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_IDLE   = 2'd2
    } phase_e;

    // Edge strobes handed to the shift register.
    typedef struct packed {
        logic lead;
        logic trail;
    } edge_stb_t;

endpackage

// File: rtl/spi_baud_decode.sv
module spi_baud_decode
    import spi_baud_pkg::*;
#(
    parameter int unsigned BRR_W = 7
) (
    input  logic [BRR_W-1:0] brr,
    output logic [BRR_W-1:0] act_len,
    output logic [BRR_W-1:0] idle_len
);

    localparam int unsigned DIV_W = BRR_W + 1;

    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] half_dn;

    always_comb begin
        if ({1'b0, brr} <= DIV_W'(SMALL_RATE_MAX)) begin
            divisor = DIV_W'(MIN_DIVISOR);
        end else begin
            divisor = {1'b0, brr} + DIV_W'(1);
        end
        // The active phase takes the floor half; the idle phase gets the rest.
        half_dn  = {1'b0, divisor[DIV_W-1:1]};
        act_len  = half_dn[BRR_W-1:0];
        idle_len = BRR_W'(divisor - half_dn);
    end

    // R4 / R5 / R6: the two phase lengths differ by at most one, and the idle phase is never shorter.
    always_comb begin
        a_r4_phase_split: assert ((idle_len == act_len) || (idle_len == act_len + BRR_W'(1)))
            else $error("phase split out of range");
    end

    // R7: no phase is shorter than two cycles.
    always_comb begin
        a_r7_min_phase: assert (act_len >= BRR_W'(2))
            else $error("phase shorter than two cycles");
    end

endmodule

// File: rtl/spi_baud_phase_cnt.sv
module spi_baud_phase_cnt #(
    parameter int unsigned LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    output logic             done
);

    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_len - LEN_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/spi_baud_clkgen.sv
module spi_baud_clkgen
    import spi_baud_pkg::*;
#(
    parameter int unsigned BRR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [BRR_W-1:0] brr,
    input  logic             cpol,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);

    localparam int unsigned RUN_W = BRR_W + 1;

    phase_e           phase_q;
    logic             pol_q;
    logic             sclk_q;
    edge_stb_t        stb_q;
    logic [BRR_W-1:0] act_q;
    logic [BRR_W-1:0] idle_q;

    logic [BRR_W-1:0] dec_act;
    logic [BRR_W-1:0] dec_idle;
    logic             cnt_done;
    logic             start_period;
    logic             enter_idle;
    logic             cnt_load;
    logic [BRR_W-1:0] cnt_len;

    spi_baud_decode #(.BRR_W(BRR_W)) u_decode (
        .brr      (brr),
        .act_len  (dec_act),
        .idle_len (dec_idle)
    );

    // A new period begins from the stopped state or after the idle phase ends.
    always_comb begin
        start_period = en && ((phase_q == PH_OFF) || ((phase_q == PH_IDLE) && cnt_done));
        enter_idle   = en && (phase_q == PH_ACTIVE) && cnt_done;
        cnt_load     = start_period || enter_idle;
        cnt_len      = start_period ? dec_act : idle_q;
    end

    spi_baud_phase_cnt #(.LEN_W(BRR_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (!en),
        .load     (cnt_load),
        .load_len (cnt_len),
        .done     (cnt_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_OFF;
            pol_q   <= 1'b0;
            sclk_q  <= 1'b0;
            stb_q   <= '0;
            act_q   <= '0;
            idle_q  <= '0;
        end else if (!en) begin
            phase_q <= PH_OFF;
            pol_q   <= cpol;
            sclk_q  <= cpol;
            stb_q   <= '0;
        end else if (start_period) begin
            phase_q <= PH_ACTIVE;
            pol_q   <= cpol;
            sclk_q  <= ~cpol;
            act_q   <= dec_act;
            idle_q  <= dec_idle;
            stb_q   <= '{lead: 1'b1, trail: 1'b0};
        end else if (enter_idle) begin
            phase_q <= PH_IDLE;
            sclk_q  <= pol_q;
            stb_q   <= '{lead: 1'b0, trail: 1'b1};
        end else begin
            stb_q   <= '0;
        end
    end

    assign sclk      = sclk_q;
    assign lead_stb  = stb_q.lead;
    assign trail_stb = stb_q.trail;

    // Cycles since the last strobe, used to check phase lengths.
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (lead_stb || trail_stb) begin
            run_len <= RUN_W'(1);
        end else if (run_len != '1) begin
            run_len <= run_len + RUN_W'(1);
        end
    end

    // R2: a low enable forces the idle level and silences both strobes.
    a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sclk == $past(cpol)) && !lead_stb && !trail_stb)
        else $error("idle level not held while disabled");

    // R9: while running, every level change of sclk comes with a strobe.
    a_r9_edge_has_strobe: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb))
        else $error("sclk moved without a strobe");

    // R10: a leading strobe always shows the non-idle level.
    a_r10_lead_level: assert property (@(posedge clk) disable iff (rst)
        lead_stb |-> (sclk != pol_q))
        else $error("leading strobe at idle level");

    // R5 / R6: the active phase lasts exactly its captured length.
    a_r5_active_len: assert property (@(posedge clk) disable iff (rst)
        trail_stb |-> (run_len == RUN_W'(act_q)))
        else $error("active phase length wrong");

    // R3 / R4: the idle phase before a back-to-back leading edge lasts its captured length.
    a_r3_idle_len: assert property (@(posedge clk) disable iff (rst)
        (lead_stb && ($past(phase_q) == PH_IDLE)) |-> (run_len == RUN_W'($past(idle_q))))
        else $error("idle phase length wrong");

endmodule

// File: tb/spi_baud_clkgen_bench.sv
module spi_baud_clkgen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BW         = 7;
    localparam int NV         = 8;

    // Table columns: rate value, polarity, expected high cycles, expected low cycles.
    localparam int V_BRR [NV] = '{0, 3, 4, 4, 5, 8, 127, 126};
    localparam int V_POL [NV] = '{0, 1, 0, 1, 0, 1, 0,   1};
    localparam int V_HI  [NV] = '{2, 2, 2, 3, 3, 5, 64,  64};
    localparam int V_LO  [NV] = '{2, 2, 3, 2, 3, 4, 64,  63};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [BW-1:0] brr = '0;
    logic          cpol = 1'b0;
    logic          sclk;
    logic          lead_stb;
    logic          trail_stb;

    int n_chk  = 0;
    int n_fail = 0;

    spi_baud_clkgen #(.BRR_W(BW)) u_spi_baud_clkgen (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .brr       (brr),
        .cpol      (cpol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Wait at falling edges until lead_stb is seen high.
    task automatic wait_lead();
        int guard;
        guard = 0;
        @(negedge clk);
        while (!lead_stb && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Count one period, starting in a cycle that shows lead_stb.
    task automatic count_period(output int hi, output int lo, output int trails, output int both);
        int guard;
        hi = 0; lo = 0; trails = 0; both = 0; guard = 0;
        do begin
            if (sclk) hi++; else lo++;
            if (trail_stb) trails++;
            if (trail_stb && lead_stb) both++;
            @(negedge clk);
            guard++;
        end while (!lead_stb && guard < 2000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got 1 expected 0");
        summary();
    end

    initial begin
        int hi;
        int lo;
        int tr;
        int bo;
        int seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sclk in reset", int'(sclk), 0);
        check("R1 strobes in reset", int'(lead_stb) + int'(trail_stb), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sclk after reset", int'(sclk), 0);
        check("R1 strobes after reset", int'(lead_stb) + int'(trail_stb), 0);

        // Table walk: R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            en = 1'b0;
            brr = BW'(V_BRR[i]);
            cpol = V_POL[i][0];
            repeat (2) @(negedge clk);
            en = 1'b1;
            wait_lead();
            count_period(hi, lo, tr, bo);
            check($sformatf("R3 R7 period rate %0d", V_BRR[i]), hi + lo, V_HI[i] + V_LO[i]);
            check($sformatf("R4 R5 R6 high rate %0d pol %0d", V_BRR[i], V_POL[i]), hi, V_HI[i]);
            check($sformatf("R4 R5 R6 low rate %0d pol %0d", V_BRR[i], V_POL[i]), lo, V_LO[i]);
            check($sformatf("R9 trail count rate %0d", V_BRR[i]), tr, 1);
            check($sformatf("R9 overlap rate %0d", V_BRR[i]), bo, 0);
            check($sformatf("R9 next lead rate %0d", V_BRR[i]), int'(lead_stb), 1);
        end

        // R2: disabled holds the polarity level, follows polarity changes
        en = 1'b0;
        cpol = 1'b1;
        @(negedge clk);
        check("R2 idle high", int'(sclk), 1);
        cpol = 1'b0;
        @(negedge clk);
        check("R2 idle low", int'(sclk), 0);
        check("R2 no strobe while off", int'(lead_stb) + int'(trail_stb), 0);

        // R10: first leading edge after enable
        brr = BW'(4);
        cpol = 1'b1;
        @(negedge clk);
        check("R10 idle before start", int'(sclk), 1);
        en = 1'b1;
        @(negedge clk);
        check("R10 sclk leaves idle", int'(sclk), 0);
        check("R10 lead strobe", int'(lead_stb), 1);
        @(negedge clk);
        check("R10 lead one cycle", int'(lead_stb), 0);

        // R2: disable in mid period
        en = 1'b0;
        @(negedge clk);
        check("R2 abort level", int'(sclk), 1);
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            if (lead_stb || trail_stb || !sclk) seen++;
            @(negedge clk);
        end
        check("R2 quiet while off", seen, 0);

        // R8: rate change during a period waits for the next leading edge
        brr = BW'(5);
        cpol = 1'b0;
        @(negedge clk);
        en = 1'b1;
        wait_lead();
        brr = BW'(9);
        count_period(hi, lo, tr, bo);
        check("R8 old period kept", hi + lo, 6);
        count_period(hi, lo, tr, bo);
        check("R8 new period", hi + lo, 10);
        check("R8 new high", hi, 5);

        en = 1'b0;
        @(negedge clk);
        summary();
    end

endmodule